// File: doc/BRIEF.md
# ADPLL Phase-Frequency Loop Controller

This block is the digital loop controller of an all-digital phase-locked loop. It runs on the fast oscillator clock. It receives two single-cycle event strobes in that clock domain: one marks a rising edge of the reference clock, the other marks a rising edge of the divided feedback clock. A free-running counter measures how many oscillator cycles lie between these events.

Phase is corrected by rewriting the feedback divider's divisor for one feedback period, so that the next feedback edge lands on a reference edge. Frequency is corrected by comparing the oscillator cycles counted in one reference period against the nominal divisor and turning that difference into a signed, shift-scaled step of the control word. After reset the controller first performs phase alignment alone. After that, it corrects both phase and frequency on every period. Once a run of quiet periods is seen, it declares lock and moves to a tracking mode. In tracking mode the control word gains fractional low-order bits and a finer gain.

Top module: `adpll_loop_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the control code to mid-scale (1024 for an 11-bit code), the fractional field to 0, the divisor to DIV_NOM, the mode to 0 and lock to 0. The mode encoding is 0 = phase alignment, 1 = frequency acquisition, 2 = tracking.
- R2: The edge gap g is the number of clock edges from the edge that samples a reference strobe to the edge that samples the next feedback strobe. A feedback strobe on the same edge as a reference strobe gives g = 0. Feedback strobes before the first reference strobe after reset are ignored.
- R3: On each accepted feedback strobe, the divisor is updated as follows. It becomes DIV_NOM-g for 0<g<=DIV_NOM/2, and 2*DIV_NOM-g for DIV_NOM/2<g<2*DIV_NOM. It becomes DIV_NOM when g=0 or g>=2*DIV_NOM. It is held until the next accepted feedback strobe, so each rewrite covers one feedback period.
- R4: In mode 0, reference strobes leave the code unchanged. The first accepted feedback strobe rewrites the divisor and moves the mode to 1. The mode never returns to 0 without reset.
- R5: On each reference strobe in mode 1 or 2, the period P is the number of edges since the previous reference strobe, saturating at 2^CNT_W-1. The error is e = P-DIV_NOM. In mode 1 the code moves by |e|>>acq_shift_i: down when e>0, up when e<0.
- R6: In mode 1 the code saturates at 0 and at 2^CODE_W-1 and never wraps.
- R7: Lock is evaluated on each reference strobe in mode 1. A period is quiet when the acquisition step is <= lock_tol_i and the phase error is also <= lock_tol_i. The phase error is g for g<=DIV_NOM/2, |g-DIV_NOM| for g<2*DIV_NOM, and otherwise the maximum value. It is taken from a feedback strobe on the same edge if there is one, else from the last accepted one. When lock_need_i consecutive quiet periods are seen (0 counts as 1), the mode becomes 2 and lock rises on that edge. A non-quiet period restarts the run. Lock then stays high until reset.
- R8: The control word is code_o followed by frac_o (FRAC_W bits), and frac_o is 0 outside mode 2. In mode 2 the whole word moves by (|e|<<FRAC_W)>>trk_shift_i, in the same direction as in R5, and saturates at 0 and all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pls_i | input | 1 | One-cycle strobe for a reference rising edge |
| fb_pls_i | input | 1 | One-cycle strobe for a feedback rising edge |
| acq_shift_i | input | SH_W | Right shift applied to the error in acquisition |
| trk_shift_i | input | SH_W | Right shift applied to the scaled error in tracking |
| lock_tol_i | input | CNT_W | Tolerance on step and phase error for lock |
| lock_need_i | input | LCK_W | Consecutive quiet periods needed for lock |
| div_o | output | DIV_W | Divisor for the feedback divider |
| code_o | output | CODE_W | Integer control code for the oscillator |
| frac_o | output | FRAC_W | Fractional control bits (tracking only) |
| mode_o | output | 2 | Loop mode: 0 phase align, 1 acquire, 2 track |
| lock_o | output | 1 | Lock flag |

## Verification
The bench builds the block with DIV_NOM = 32, CODE_W = 11 and FRAC_W = 4. This gives an 8-bit cycle counter that saturates at 255. With these values, both divisor folding branches and the beyond-two-periods branch are reached with gaps of a few tens of cycles. The saturated period count gives an acquisition step of 223 at zero shift, so the code floor is reached in five reference periods. Short two-cycle periods drive the code to its ceiling in under seventy periods. The 4-bit fraction makes the tracking ceiling and the fine down-steps visible as distinct frac_o values.

// File: rtl/adpll_ctrl_pkg.sv
package adpll_ctrl_pkg;

  typedef enum logic [1:0] {
    MODE_PHASE = 2'd0,
    MODE_FREQ  = 2'd1,
    MODE_TRACK = 2'd2
  } loop_mode_e;

endpackage

// File: rtl/adpll_edge_timer.sv
// Counts oscillator cycles since the last reference strobe.
module adpll_edge_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_pls_i,
  output logic             ref_seen_o,
  output logic [CNT_W-1:0] gap_o,
  output logic [CNT_W-1:0] period_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      ref_seen_o <= 1'b0;
    end else if (ref_pls_i) begin
      cnt_q      <= CNT_W'(1);
      ref_seen_o <= 1'b1;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // period seen at a reference strobe; gap seen at a feedback strobe
  assign period_o = cnt_q;
  assign gap_o    = ref_pls_i ? '0 : cnt_q;

endmodule

// File: rtl/adpll_phase_corr.sv
// Folds an edge gap onto the nearest reference edge and derives the
// one-period divisor and the phase error magnitude.
module adpll_phase_corr #(
  parameter int DIV_NOM = 32,
  parameter int CNT_W   = 8,
  parameter int DIV_W   = 7
) (
  input  logic [CNT_W-1:0] gap_i,
  output logic [DIV_W-1:0] div_o,
  output logic [CNT_W-1:0] perr_o
);

  localparam int XW = CNT_W + 2;
  localparam logic [XW-1:0] NOM   = XW'(DIV_NOM);
  localparam logic [XW-1:0] HALF  = XW'(DIV_NOM / 2);
  localparam logic [XW-1:0] TWICE = XW'(2 * DIV_NOM);

  logic [XW-1:0] g;
  logic [XW-1:0] d;
  logic [XW-1:0] e;

  always_comb begin
    g = XW'(gap_i);
    if (g == '0) begin
      d = NOM;
      e = '0;
    end else if (g >= TWICE) begin
      d = NOM;
      e = '1;
    end else if (g <= HALF) begin
      // feedback late: shorten the next period
      d = NOM - g;
      e = g;
    end else begin
      // feedback belongs to the coming reference edge
      d = TWICE - g;
      e = (g >= NOM) ? (g - NOM) : (NOM - g);
    end
    div_o  = DIV_W'(d);
    perr_o = CNT_W'(e);
  end

endmodule

// File: rtl/adpll_freq_step.sv
// Converts a reference-period cycle count into a saturating control word update.
module adpll_freq_step #(
  parameter int DIV_NOM = 32,
  parameter int CNT_W   = 8,
  parameter int CODE_W  = 11,
  parameter int FRAC_W  = 4,
  parameter int SH_W    = 4
) (
  input  logic [CNT_W-1:0]         period_i,
  input  logic [SH_W-1:0]          acq_shift_i,
  input  logic [SH_W-1:0]          trk_shift_i,
  input  logic                     track_i,
  input  logic [CODE_W+FRAC_W-1:0] word_i,
  output logic [CODE_W+FRAC_W-1:0] word_o,
  output logic [CNT_W-1:0]         step_o
);

  localparam int WORD_W = CODE_W + FRAC_W;
  localparam int XW     = WORD_W + CNT_W + 1;
  localparam logic [CNT_W-1:0] NOM     = CNT_W'(DIV_NOM);
  localparam logic [XW-1:0]    TOP_TRK = XW'({WORD_W{1'b1}});
  localparam logic [XW-1:0]    TOP_ACQ = XW'({CODE_W{1'b1}}) << FRAC_W;

  logic             fast;
  logic [CNT_W-1:0] mag;
  logic [XW-1:0]    fine;
  logic [XW-1:0]    stp;
  logic [XW-1:0]    cur;
  logic [XW-1:0]    lim;
  logic [XW-1:0]    sum;

  always_comb begin
    fast   = period_i > NOM;
    mag    = fast ? (period_i - NOM) : (NOM - period_i);
    step_o = mag >> acq_shift_i;
    fine   = (XW'(mag) << FRAC_W) >> trk_shift_i;
    stp    = track_i ? fine : (XW'(step_o) << FRAC_W);
    cur    = XW'(word_i);
    lim    = track_i ? TOP_TRK : TOP_ACQ;
    sum    = cur + stp;
    if (fast) begin
      word_o = (stp >= cur) ? '0 : WORD_W'(cur - stp);
    end else begin
      word_o = (sum > lim) ? WORD_W'(lim) : WORD_W'(sum);
    end
  end

endmodule

// File: rtl/adpll_lock_detect.sv
// Counts consecutive quiet reference periods.
module adpll_lock_detect #(
  parameter int LCK_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eval_i,
  input  logic             quiet_i,
  input  logic [LCK_W-1:0] need_i,
  output logic             hit_o
);

  logic [LCK_W-1:0] run_q;
  logic [LCK_W:0]   run_nx;
  logic [LCK_W:0]   need_eff;

  always_comb begin
    run_nx   = {1'b0, run_q} + 1'b1;
    need_eff = (need_i == '0) ? (LCK_W+1)'(1) : {1'b0, need_i};
    hit_o    = eval_i && quiet_i && (run_nx >= need_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (eval_i) begin
      if (!quiet_i) begin
        run_q <= '0;
      end else if (run_q != '1) begin
        run_q <= run_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/adpll_loop_ctrl.sv
module adpll_loop_ctrl #(
  parameter int DIV_NOM = 32,
  parameter int CODE_W  = 11,
  parameter int FRAC_W  = 4,
  parameter int SH_W    = 4,
  parameter int LCK_W   = 8,
  parameter int CNT_W   = $clog2(4 * DIV_NOM) + 1,
  parameter int DIV_W   = $clog2(2 * DIV_NOM) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_pls_i,
  input  logic              fb_pls_i,
  input  logic [SH_W-1:0]   acq_shift_i,
  input  logic [SH_W-1:0]   trk_shift_i,
  input  logic [CNT_W-1:0]  lock_tol_i,
  input  logic [LCK_W-1:0]  lock_need_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [CODE_W-1:0] code_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic [1:0]        mode_o,
  output logic              lock_o
);
  import adpll_ctrl_pkg::*;

  localparam int WORD_W = CODE_W + FRAC_W;
  localparam logic [WORD_W-1:0] WORD_MID = WORD_W'(1 << (CODE_W - 1)) << FRAC_W;
  localparam logic [DIV_W-1:0]  DIV_RST  = DIV_W'(DIV_NOM);

  loop_mode_e        mode_q;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;
  logic [DIV_W-1:0]  div_q;
  logic [DIV_W-1:0]  div_nx;
  logic [CNT_W-1:0]  perr_q;
  logic [CNT_W-1:0]  perr_nx;
  logic [CNT_W-1:0]  perr_eff;
  logic [CNT_W-1:0]  gap;
  logic [CNT_W-1:0]  period;
  logic [CNT_W-1:0]  step_acq;
  logic              ref_seen;
  logic              lock_q;
  logic              fb_ok;
  logic              freq_upd;
  logic              lock_eval;
  logic              quiet;
  logic              lock_hit;

  adpll_edge_timer #(.CNT_W(CNT_W)) timer_i (
    .clk        (clk),
    .rst        (rst),
    .ref_pls_i  (ref_pls_i),
    .ref_seen_o (ref_seen),
    .gap_o      (gap),
    .period_o   (period)
  );

  adpll_phase_corr #(.DIV_NOM(DIV_NOM), .CNT_W(CNT_W), .DIV_W(DIV_W)) phase_i (
    .gap_i  (gap),
    .div_o  (div_nx),
    .perr_o (perr_nx)
  );

  adpll_freq_step #(
    .DIV_NOM(DIV_NOM), .CNT_W(CNT_W), .CODE_W(CODE_W), .FRAC_W(FRAC_W), .SH_W(SH_W)
  ) freq_i (
    .period_i    (period),
    .acq_shift_i (acq_shift_i),
    .trk_shift_i (trk_shift_i),
    .track_i     (mode_q == MODE_TRACK),
    .word_i      (word_q),
    .word_o      (word_d),
    .step_o      (step_acq)
  );

  always_comb begin
    fb_ok     = fb_pls_i && ref_seen;
    freq_upd  = ref_pls_i && (mode_q != MODE_PHASE);
    lock_eval = ref_pls_i && (mode_q == MODE_FREQ);
    perr_eff  = fb_ok ? perr_nx : perr_q;
    quiet     = (step_acq <= lock_tol_i) && (perr_eff <= lock_tol_i);
  end

  adpll_lock_detect #(.LCK_W(LCK_W)) lock_i (
    .clk     (clk),
    .rst     (rst),
    .eval_i  (lock_eval),
    .quiet_i (quiet),
    .need_i  (lock_need_i),
    .hit_o   (lock_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_PHASE;
      word_q <= WORD_MID;
      div_q  <= DIV_RST;
      perr_q <= '0;
      lock_q <= 1'b0;
    end else begin
      if (fb_ok) begin
        div_q  <= div_nx;
        perr_q <= perr_nx;
        if (mode_q == MODE_PHASE) begin
          mode_q <= MODE_FREQ;
        end
      end
      if (freq_upd) begin
        word_q <= word_d;
      end
      if (lock_hit) begin
        mode_q <= MODE_TRACK;
        lock_q <= 1'b1;
      end
    end
  end

  assign div_o  = div_q;
  assign code_o = word_q[WORD_W-1:FRAC_W];
  assign frac_o = word_q[FRAC_W-1:0];
  assign mode_o = mode_q;
  assign lock_o = lock_q;

endmodule

// File: rtl/adpll_loop_ctrl_chk.sv
module adpll_loop_ctrl_chk #(
  parameter int CODE_W = 11,
  parameter int FRAC_W = 4,
  parameter int DIV_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              ref_pls_i,
  input logic              fb_pls_i,
  input logic [DIV_W-1:0]  div_o,
  input logic [CODE_W-1:0] code_o,
  input logic [FRAC_W-1:0] frac_o,
  input logic [1:0]        mode_o,
  input logic              lock_o
);

  assert_mode_legal_R1: assert property (@(posedge clk) disable iff (rst)
    mode_o != 2'd3);

  assert_div_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !fb_pls_i |=> $stable(div_o));

  assert_div_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    div_o != '0);

  assert_phase_stay_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd0 && !fb_pls_i) |=> (mode_o == 2'd0));

  assert_no_return_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_o != 2'd0) |=> (mode_o != 2'd0));

  assert_code_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!ref_pls_i || mode_o == 2'd0) |=> ($stable(code_o) && $stable(frac_o)));

  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    lock_o |=> (lock_o && mode_o == 2'd2));

  assert_frac_acq_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_o != 2'd2) |-> (frac_o == '0));

endmodule

bind adpll_loop_ctrl adpll_loop_ctrl_chk #(
  .CODE_W(CODE_W), .FRAC_W(FRAC_W), .DIV_W(DIV_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .ref_pls_i (ref_pls_i),
  .fb_pls_i  (fb_pls_i),
  .div_o     (div_o),
  .code_o    (code_o),
  .frac_o    (frac_o),
  .mode_o    (mode_o),
  .lock_o    (lock_o)
);

// File: tb/adpll_loop_ctrl_tb_top.sv
`timescale 1ns/1ps
module adpll_loop_ctrl_tb_top;

  localparam int DIV_NOM = 32;
  localparam int CODE_W  = 11;
  localparam int FRAC_W  = 4;
  localparam int SH_W    = 4;
  localparam int LCK_W   = 8;
  localparam int CNT_W   = 8;
  localparam int DIV_W   = 7;
  localparam int NROW    = 12;

  // columns: len, gap, div@ref, code, frac, mode, lock, div@fb, mode@fb
  localparam int VEC [NROW][9] = '{
    '{40,  5, 32, 1024, 0, 0, 0, 27, 1},
    '{40,  0, 32, 1020, 0, 1, 0, 32, 1},
    '{26, 20, 32, 1016, 0, 1, 0, 44, 1},
    '{33,  3, 44, 1019, 0, 1, 0, 29, 1},
    '{32,  1, 29, 1019, 0, 1, 0, 31, 1},
    '{31,  0, 32, 1019, 0, 1, 0, 32, 1},
    '{32,  1, 32, 1019, 0, 1, 0, 31, 1},
    '{32,  2, 31, 1019, 0, 2, 1, 30, 2},
    '{30,  0, 32, 1019, 0, 2, 1, 32, 2},
    '{32,  1, 32, 1019, 4, 2, 1, 31, 2},
    '{31,  0, 32, 1019, 4, 2, 1, 32, 2},
    '{10,  3, 32, 1019, 6, 2, 1, 29, 2}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ref_pls = 1'b0;
  logic              fb_pls = 1'b0;
  logic [SH_W-1:0]   acq_shift = 4'd1;
  logic [SH_W-1:0]   trk_shift = 4'd3;
  logic [CNT_W-1:0]  lock_tol = 8'd1;
  logic [LCK_W-1:0]  lock_need = 8'd3;
  logic [DIV_W-1:0]  div_o;
  logic [CODE_W-1:0] code_o;
  logic [FRAC_W-1:0] frac_o;
  logic [1:0]        mode_o;
  logic              lock_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  adpll_loop_ctrl #(
    .DIV_NOM(DIV_NOM), .CODE_W(CODE_W), .FRAC_W(FRAC_W), .SH_W(SH_W), .LCK_W(LCK_W)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .ref_pls_i   (ref_pls),
    .fb_pls_i    (fb_pls),
    .acq_shift_i (acq_shift),
    .trk_shift_i (trk_shift),
    .lock_tol_i  (lock_tol),
    .lock_need_i (lock_need),
    .div_o       (div_o),
    .code_o      (code_o),
    .frac_o      (frac_o),
    .mode_o      (mode_o),
    .lock_o      (lock_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // drive strobes for one edge, return just after it
  task automatic pulse(input bit r, input bit f);
    ref_pls = r;
    fb_pls  = f;
    @(posedge clk);
    #1;
    ref_pls = 1'b0;
    fb_pls  = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) pulse(1'b0, 1'b0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(posedge clk);
    #1;
    do_reset();
    // R1 reset state
    chk("R1", "div", div_o, 32);
    chk("R1", "code", code_o, 1024);
    chk("R1", "frac", frac_o, 0);
    chk("R1", "mode", mode_o, 0);
    chk("R1", "lock", lock_o, 0);

    // vector table: acquisition, lock and tracking
    for (int r = 0; r < NROW; r++) begin
      for (int k = 0; k < VEC[r][0]; k++) begin
        pulse(k == 0, k == VEC[r][1]);
        if (k == 0) begin
          chk("R5", "code", code_o, VEC[r][3]);
          chk("R8", "frac", frac_o, VEC[r][4]);
          chk("R7", "mode", mode_o, VEC[r][5]);
          chk("R7", "lock", lock_o, VEC[r][6]);
          chk("R3", "div@ref", div_o, (VEC[r][1] == 0) ? VEC[r][7] : VEC[r][2]);
        end else if (k == VEC[r][1]) begin
          chk("R3", "div@fb", div_o, VEC[r][7]);
          chk("R4", "mode@fb", mode_o, VEC[r][8]);
        end
      end
    end

    // R2/R3/R4 directed: ignored feedback, phase-only phase, fold branches
    acq_shift = 4'd15;
    lock_tol  = 8'd0;
    lock_need = 8'd200;
    do_reset();
    pulse(1'b0, 1'b1);
    chk("R2", "div after early fb", div_o, 32);
    chk("R2", "mode after early fb", mode_o, 0);
    acq_shift = 4'd0;
    pulse(1'b1, 1'b0);
    idle(49);
    pulse(1'b1, 1'b0);
    chk("R4", "code in phase mode", code_o, 1024);
    chk("R4", "mode in phase mode", mode_o, 0);
    acq_shift = 4'd15;
    idle(15);
    pulse(1'b0, 1'b1);
    chk("R3", "div gap16", div_o, 16);
    chk("R4", "mode after align", mode_o, 1);
    pulse(1'b1, 1'b0);
    idle(16);
    pulse(1'b0, 1'b1);
    chk("R3", "div gap17", div_o, 47);
    idle(1);
    chk("R3", "div held", div_o, 47);
    pulse(1'b1, 1'b0);
    chk("R3", "div held at ref", div_o, 47);
    idle(39);
    pulse(1'b0, 1'b1);
    chk("R3", "div gap40", div_o, 24);
    pulse(1'b1, 1'b0);
    idle(69);
    pulse(1'b0, 1'b1);
    chk("R3", "div gap70", div_o, 32);
    chk("R2", "code with tiny gain", code_o, 1024);

    // R6 saturation at both ends
    acq_shift = 4'd0;
    lock_tol  = 8'd0;
    lock_need = 8'd200;
    do_reset();
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    chk("R3", "div gap1", div_o, 31);
    for (int i = 1; i <= 6; i++) begin
      idle(299);
      pulse(1'b1, 1'b0);
      if (i == 1) chk("R5", "code slow step", code_o, 801);
      if (i == 5) chk("R6", "code floor", code_o, 0);
      if (i == 6) chk("R6", "code floor held", code_o, 0);
    end
    for (int i = 1; i <= 80; i++) begin
      pulse(1'b0, 1'b0);
      pulse(1'b1, 1'b0);
      if (i == 1)  chk("R5", "code fast step", code_o, 30);
      if (i == 68) chk("R6", "code near top", code_o, 2040);
      if (i == 69) chk("R6", "code ceiling", code_o, 2047);
    end
    chk("R6", "code ceiling held", code_o, 2047);
    chk("R8", "frac in acq", frac_o, 0);
    chk("R7", "no lock", lock_o, 0);

    // R7 need=0 acts as 1; R8 tracking saturation and fine steps
    lock_tol  = 8'd255;
    lock_need = 8'd0;
    pulse(1'b0, 1'b0);
    pulse(1'b1, 1'b0);
    chk("R7", "mode after lock", mode_o, 2);
    chk("R7", "lock after one quiet", lock_o, 1);
    chk("R6", "code clamp at lock", code_o, 2047);
    pulse(1'b0, 1'b0);
    pulse(1'b1, 1'b0);
    chk("R8", "track ceiling code", code_o, 2047);
    chk("R8", "track ceiling frac", frac_o, 15);
    idle(32);
    pulse(1'b1, 1'b0);
    chk("R8", "track fine down frac", frac_o, 13);
    chk("R8", "track fine down code", code_o, 2047);
    chk("R7", "lock sticky", lock_o, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule